// File: doc/BRIEF.md
# Latched Source-Select Output Mux

This block picks one of three configuration sources and drives the result onto a 5-bit open-drain output word. The sources are a 5-bit external input port and two 6-bit persistent configuration words, A and B, which are held elsewhere. A 2-bit select from board pins normally makes the choice. A control value can replace the pins once the serial side strobes it into a small override register. Storage and the serial interface sit outside this block.

A sixth output, the auxiliary bit, carries the top bit (bit 5) of the selected configuration word. It passes through a hold stage that is controlled by bit 0 of the effective select. While that bit is 0 the auxiliary output follows its source. While it is 1 the output keeps the value captured on the last clock edge at which the bit was 0. Every output is shown as a pull-down enable. The enable is 1 when the line must be pulled low, which is when the bit value is 0.

Top module: `osm_top`

## Requirements
- R1: With effective select 2'b00 the output word value equals `ext_in`.
- R2: With effective select 2'b01 or 2'b11 the output word value equals `cfg_a[4:0]`.
- R3: With effective select 2'b10 the output word value equals `cfg_b[4:0]`.
- R4: A clock edge with `ovr_wr`=1 loads `ovr_on` and `ovr_sel`. From the next cycle, `ovr_on`=1 makes `ovr_sel` the effective select and the pins are ignored. `ovr_on`=0 hands control back to `sel_pin`.
- R5: The live auxiliary bit is `cfg_b[5]` for effective select 2'b10. For every other select it is `cfg_a[5]`.
- R6: While effective select bit 0 is 0, the auxiliary output equals the live bit in the same cycle. While that bit is 1, the output keeps the live bit sampled at the last clock edge at which select bit 0 was 0.
- R7: Outputs are active-high pull-down enables: `word_pull[i]` is 1 exactly when word bit i is 0, and `aux_pull` is 1 exactly when the auxiliary bit is 0.
- R8: Synchronous reset (`rst_n`=0 at a clock edge) clears the override. While `rst_n` is 0 the pins alone choose the source, and the hold stage loads the live bit on every edge.
- R9: If configuration word B holds zeros, `sel_pin`=2'b10 pulls every word line low, so select bit 1 works as a legacy force-low pin.
- R10: Changes on `ovr_on` and `ovr_sel` without `ovr_wr` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_pin | input | 2 | Board select pins (an unconnected pin reads 1) |
| ext_in | input | 5 | External input port |
| cfg_a | input | 6 | Persistent configuration word A |
| cfg_b | input | 6 | Persistent configuration word B |
| ovr_wr | input | 1 | Strobe that loads the override register |
| ovr_on | input | 1 | Override enable value to load |
| ovr_sel | input | 2 | Override select value to load |
| word_pull | output | 5 | Pull-down enables of the output word |
| aux_pull | output | 1 | Pull-down enable of the auxiliary bit |

## Verification
The assertions assume that `ovr_wr`, `ovr_on` and `ovr_sel` change only between clock edges. They also assume that reset lasts at least one edge before any override check matters, because the override register has no defined value until its first reset. The stimulus changes every input on the falling edge and samples the outputs shortly after, before the next rising edge. It holds `rst_n` low for several edges, so the history that the hold stage and the override register depend on is always defined.

// File: rtl/osm_pkg.sv
package osm_pkg;

  typedef enum logic [1:0] {
    SRC_PINS  = 2'b00,
    SRC_CFG_A = 2'b01,
    SRC_CFG_B = 2'b10,
    SRC_CFG_X = 2'b11
  } src_e;

  typedef struct packed {
    logic       on;
    logic [1:0] sel;
  } ovr_t;

  // Bit 0 of the effective select closes the auxiliary hold stage.
  function automatic logic hold_of(src_e s);
    return s[0];
  endfunction

endpackage

// File: rtl/osm_sel_ctrl.sv
module osm_sel_ctrl
  import osm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_pin,
  input  logic       ovr_wr,
  input  logic       ovr_on,
  input  logic [1:0] ovr_sel,
  output src_e       eff_sel,
  output logic       ovr_active,
  output logic       hold
);

  ovr_t ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ovr_q <= '0;
    else if (ovr_wr) ovr_q <= '{on: ovr_on, sel: ovr_sel};
  end

  // During reset the pins decide, even before the register is defined.
  assign ovr_active = rst_n && ovr_q.on;
  assign eff_sel    = ovr_active ? src_e'(ovr_q.sel) : src_e'(sel_pin);
  assign hold       = hold_of(eff_sel);

  p_ovr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_wr |=> (ovr_q.on == $past(ovr_on)) && (ovr_q.sel == $past(ovr_sel)));

  p_ovr_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_wr |=> $stable(ovr_q));

endmodule

// File: rtl/osm_src_mux.sv
module osm_src_mux
  import osm_pkg::*;
#(
  parameter int WORD_W = 5,
  parameter int CFG_W  = 6
) (
  input  src_e              eff_sel,
  input  logic [WORD_W-1:0] ext_in,
  input  logic [CFG_W-1:0]  cfg_a,
  input  logic [CFG_W-1:0]  cfg_b,
  output logic [WORD_W-1:0] word_val,
  output logic              top_live
);

  localparam int TOP = CFG_W - 1;

  function automatic logic [WORD_W-1:0] pick_word(src_e s, logic [WORD_W-1:0] e,
                                                  logic [CFG_W-1:0] a, logic [CFG_W-1:0] b);
    unique case (s)
      SRC_PINS:  return e;
      SRC_CFG_B: return b[WORD_W-1:0];
      default:   return a[WORD_W-1:0];
    endcase
  endfunction

  function automatic logic pick_top(src_e s, logic [CFG_W-1:0] a, logic [CFG_W-1:0] b);
    return (s == SRC_CFG_B) ? b[TOP] : a[TOP];
  endfunction

  assign word_val = pick_word(eff_sel, ext_in, cfg_a, cfg_b);
  assign top_live = pick_top(eff_sel, cfg_a, cfg_b);

  always_comb begin
    if (eff_sel == SRC_CFG_B)
      p_top_b_r5: assert (top_live == cfg_b[TOP] || $isunknown(cfg_b));
  end

endmodule

// File: rtl/osm_hold_latch.sv
module osm_hold_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic live,
  output logic cap_q,
  output logic aux_val
);

  always_ff @(posedge clk) begin
    if (!rst_n || !hold) cap_q <= live;
  end

  assign aux_val = hold ? cap_q : live;

  p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(cap_q));

  p_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> cap_q == $past(live));

endmodule

// File: rtl/osm_top.sv
module osm_top
  import osm_pkg::*;
#(
  parameter int WORD_W = 5,
  parameter int CFG_W  = WORD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel_pin,
  input  logic [WORD_W-1:0] ext_in,
  input  logic [CFG_W-1:0]  cfg_a,
  input  logic [CFG_W-1:0]  cfg_b,
  input  logic              ovr_wr,
  input  logic              ovr_on,
  input  logic [1:0]        ovr_sel,
  output logic [WORD_W-1:0] word_pull,
  output logic              aux_pull
);

  src_e              eff_sel;
  logic              ovr_active;
  logic              hold;
  logic [WORD_W-1:0] word_val;
  logic              top_live;
  logic              cap_q;
  logic              aux_val;

  osm_sel_ctrl u_sel (
    .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .ovr_wr(ovr_wr),
    .ovr_on(ovr_on), .ovr_sel(ovr_sel), .eff_sel(eff_sel),
    .ovr_active(ovr_active), .hold(hold)
  );

  osm_src_mux #(.WORD_W(WORD_W), .CFG_W(CFG_W)) u_mux (
    .eff_sel(eff_sel), .ext_in(ext_in), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .word_val(word_val), .top_live(top_live)
  );

  osm_hold_latch u_hold (
    .clk(clk), .rst_n(rst_n), .hold(hold), .live(top_live),
    .cap_q(cap_q), .aux_val(aux_val)
  );

  // Open-drain view: one pull-down enable per line.
  for (genvar i = 0; i < WORD_W; i++) begin : g_od
    assign word_pull[i] = ~word_val[i];
  end
  assign aux_pull = ~aux_val;

  p_pins_ext_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_active && sel_pin == 2'b00) |-> word_pull == ~ext_in);

  p_legacy_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_active && sel_pin == 2'b10 && cfg_b[WORD_W-1:0] == '0) |-> &word_pull);

endmodule

// File: tb/osm_top_tb.sv
module osm_top_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sel_pin;
  logic [4:0] ext_in;
  logic [5:0] cfg_a, cfg_b;
  logic       ovr_wr, ovr_on;
  logic [1:0] ovr_sel;
  logic [4:0] word_pull;
  logic       aux_pull;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  osm_top u_dut (
    .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .ext_in(ext_in),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .ovr_wr(ovr_wr), .ovr_on(ovr_on),
    .ovr_sel(ovr_sel), .word_pull(word_pull), .aux_pull(aux_pull)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic [4:0] ext;
    logic [5:0] a;
    logic [5:0] b;
    logic [4:0] word;
    logic       aux;
  } vec_t;

  // Expected values are bit values; the bench compares them to inverted pulls.
  localparam vec_t VEC [8] = '{
    '{2'b00, 5'h15, 6'h2A, 6'h13, 5'h15, 1'b1},  // R1 R5
    '{2'b10, 5'h15, 6'h2A, 6'h13, 5'h13, 1'b0},  // R3 R5
    '{2'b01, 5'h15, 6'h2A, 6'h13, 5'h0A, 1'b0},  // R2, held value R6
    '{2'b11, 5'h15, 6'h07, 6'h13, 5'h07, 1'b0},  // R2 alias, still held R6
    '{2'b00, 5'h1F, 6'h3F, 6'h13, 5'h1F, 1'b1},  // R1 all ones R7
    '{2'b11, 5'h1F, 6'h00, 6'h13, 5'h00, 1'b1},  // held one R6
    '{2'b10, 5'h1F, 6'h00, 6'h00, 5'h00, 1'b0},  // legacy force-low R9
    '{2'b00, 5'h00, 6'h20, 6'h00, 5'h00, 1'b1}   // R1 zeros, R5
  };

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, logic [4:0] w, logic a);
    check(req, {~aux_pull, ~word_pull}, {a, w});
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; sel_pin = 2'b01; ext_in = 5'h0C;
    cfg_a = 6'h25; cfg_b = 6'h12;
    ovr_wr = 1'b0; ovr_on = 1'b0; ovr_sel = 2'b00;

    // R8: in reset the pins decide; the hold stage loads cfg_a[5] = 1
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk_out("R8 reset word/aux", 5'h05, 1'b1);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk_out("R8 held after reset", 5'h05, 1'b1);

    // Vector table walk
    foreach (VEC[k]) begin
      @(negedge clk);
      sel_pin = VEC[k].sel; ext_in = VEC[k].ext; cfg_a = VEC[k].a; cfg_b = VEC[k].b;
      #2;
      chk_out($sformatf("R1/R2/R3/R5/R6/R7 vector %0d", k), VEC[k].word, VEC[k].aux);
    end

    // R4: override to select B while pins pick the external port
    @(negedge clk);
    sel_pin = 2'b00; ext_in = 5'h11; cfg_a = 6'h0E; cfg_b = 6'h19;
    ovr_on = 1'b1; ovr_sel = 2'b10; ovr_wr = 1'b1;
    #2;
    chk_out("R4 before load", 5'h11, 1'b0);
    @(negedge clk); ovr_wr = 1'b0; #2;
    chk_out("R4 override to B", 5'h19, 1'b0);

    // R10: new values without the strobe are ignored
    ovr_on = 1'b0; ovr_sel = 2'b00;
    @(negedge clk); @(negedge clk); #2;
    chk_out("R10 no strobe", 5'h19, 1'b0);

    // R4: pins ignored while override active
    sel_pin = 2'b01; #1;
    chk_out("R4 pins ignored", 5'h19, 1'b0);

    // R4: release returns control to the pins (01 -> cfg_a, aux held from B = 0)
    ovr_wr = 1'b1;
    @(negedge clk); ovr_wr = 1'b0; #2;
    chk_out("R4 release", 5'h0E, 1'b0);

    // R8: reset clears a set override
    ovr_on = 1'b1; ovr_sel = 2'b10; ovr_wr = 1'b1; sel_pin = 2'b00;
    @(negedge clk); ovr_wr = 1'b0; #2;
    chk_out("R4 set again", 5'h19, 1'b0);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    chk_out("R8 override cleared", 5'h11, 1'b0);

    // R6: transparent tracking of live bit within a cycle (select B)
    sel_pin = 2'b10; cfg_b = 6'h20; #1;
    chk_out("R6 transparent B", 5'h00, 1'b1);

    finish_run();
  end

endmodule